// File: doc/BRIEF.md
# Per-Path Frequency Offset Accumulator

This block collects signed carrier frequency offset reports, one per receive path, from every received packet that belongs to the associated peer. Each such packet adds each active path's offset to that path's running signed sum, increments that path's report count, and increments a packet counter that runs freely across clears.

A tracking controller reads the sums and counts from packed output vectors. It compares the packet counter with the value it saw last time to tell whether any new traffic has arrived. It then clears the sums and counts with a single-cycle pulse. The controller converts the sums to physical units and does any averaging; neither happens here.

The number of paths a packet updates is the smallest of three values: the stream count carried with the packet, the configured number of active paths, and the number of lanes the block was built with.

Top module: `cfo_accum`

## Requirements
- R1: After reset every path sum, every path count and the packet counter read zero.
- R2: A cycle with `pkt_valid_i` low, or with `pkt_valid_i` high and `pkt_match_i` low, leaves every sum, every count and the packet counter unchanged.
- R3: With `en_i` low, no packet changes any sum, count or the packet counter.
- R4: A qualifying packet updates path i only when i < min(`nss_i`, `act_paths_i`, MAX_PATHS). Paths at or above that limit keep their values. Path i sits at bits [i*SUM_W +: SUM_W] of `sum_o` and at bits [i*CNT_W +: CNT_W] of `cnt_o`. Path i's offset is byte i of `ofs_i`, in two's complement.
- R5: For each updated path, the sum grows by that path's signed offset and the count grows by one. Both are visible on the outputs in the cycle after the packet.
- R6: The packet counter increments once per qualifying packet, whatever the stream count, including zero. From all ones it goes to zero.
- R7: A pulse on `clear_i` sets every sum and count to zero in the next cycle. The packet counter is not affected.
- R8: When `clear_i` and a qualifying packet arrive in the same cycle, the clear takes effect first. The result equals that packet alone applied to zeroed state.
- R9: A path sum saturates at the largest positive and the most negative SUM_W-bit two's complement values instead of wrapping.
- R10: A path count saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global accumulation enable |
| pkt_valid_i | input | 1 | One-cycle strobe per received packet report |
| pkt_match_i | input | 1 | Packet belongs to the associated peer |
| nss_i | input | NSS_W | Stream count carried with the packet |
| act_paths_i | input | NSS_W | Configured number of active receive paths |
| ofs_i | input | MAX_PATHS*OFS_W | Per-path signed offsets, path i in byte i |
| clear_i | input | 1 | Zero all sums and counts |
| sum_o | output | MAX_PATHS*SUM_W | Per-path signed offset sums |
| cnt_o | output | MAX_PATHS*CNT_W | Per-path report counts |
| pkt_cnt_o | output | PKT_W | Qualifying packet counter |

## Verification
Every piece of state is a register driven straight to a port. A wrong lane gate, a bad saturation limit or a mishandled clear therefore shows up on `sum_o`, `cnt_o` or `pkt_cnt_o` one cycle after the packet that triggers it. The bench builds a small configuration so that saturation and counter wrap are reached within a few hundred packets. It sweeps every pair of stream count and active path count and compares all lanes after every cycle. A divergence is caught on the very next cycle and does not depend on an accumulated drift.

// File: rtl/cfo_accum_pkg.sv
package cfo_accum_pkg;

  function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/cfo_lane_select.sv
module cfo_lane_select #(
  parameter int MAX_PATHS = 4,
  parameter int NSS_W     = 3
) (
  input  logic [NSS_W-1:0]     nss_i,
  input  logic [NSS_W-1:0]     act_i,
  output logic [MAX_PATHS-1:0] lane_en_o
);
  import cfo_accum_pkg::*;

  logic [NSS_W-1:0] eff;

  always_comb begin
    eff = NSS_W'(min3(int'(nss_i), int'(act_i), MAX_PATHS));
  end

  for (genvar i = 0; i < MAX_PATHS; i++) begin : g_en
    assign lane_en_o[i] = (eff > NSS_W'(i));
  end

  always_comb begin
    a_r4_lane_limit: assert ($countones(lane_en_o) <= int'(nss_i) &&
                             $countones(lane_en_o) <= int'(act_i));
  end

endmodule

// File: rtl/cfo_path_lane.sv
module cfo_path_lane #(
  parameter int OFS_W = 8,
  parameter int SUM_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             acc_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [SUM_W-1:0] SMAX = {1'b0, {(SUM_W-1){1'b1}}};
  localparam logic [SUM_W-1:0] SMIN = {1'b1, {(SUM_W-1){1'b0}}};
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [SUM_W-1:0] sum_q, sum_d, base_sum;
  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;
  logic [SUM_W:0]   wide;

  always_comb begin
    // clear first, then the packet's contribution
    base_sum = clr_i ? '0 : sum_q;
    base_cnt = clr_i ? '0 : cnt_q;
    wide = {base_sum[SUM_W-1], base_sum} +
           {{(SUM_W+1-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
    sum_d = base_sum;
    cnt_d = base_cnt;
    if (acc_i) begin
      if (wide[SUM_W] != wide[SUM_W-1]) sum_d = wide[SUM_W] ? SMIN : SMAX;
      else                              sum_d = wide[SUM_W-1:0];
      if (base_cnt != CMAX) cnt_d = base_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else begin
      sum_q <= sum_d;
      cnt_q <= cnt_d;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;

  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !acc_i) |=> ($stable(sum_o) && $stable(cnt_o)));
  a_r7_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !acc_i) |=> (sum_o == '0 && cnt_o == '0));
  a_r8_clear_then_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && acc_i) |=> (cnt_o == CNT_W'(1)));
  a_r10_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_o == CMAX) |=> (cnt_o == CMAX));
  a_r9_sum_sat_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_i && !ofs_i[OFS_W-1] && sum_o == SMAX) |=> (sum_o == SMAX));
  a_r9_sum_sat_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_i && ofs_i[OFS_W-1] && sum_o == SMIN) |=> (sum_o == SMIN));

endmodule

// File: rtl/cfo_pkt_counter.sv
module cfo_pkt_counter #(
  parameter int PKT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [PKT_W-1:0] cnt_o
);
  localparam logic [PKT_W-1:0] PMAX = '1;

  logic [PKT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (inc_i)    cnt_q <= (cnt_q == PMAX) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
  a_r6_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_o == PMAX) |=> (cnt_o == '0));

endmodule

// File: rtl/cfo_accum.sv
module cfo_accum #(
  parameter int MAX_PATHS = 4,
  parameter int OFS_W     = 8,
  parameter int SUM_W     = 24,
  parameter int CNT_W     = 16,
  parameter int PKT_W     = 32,
  parameter int NSS_W     = $clog2(MAX_PATHS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       pkt_valid_i,
  input  logic                       pkt_match_i,
  input  logic [NSS_W-1:0]           nss_i,
  input  logic [NSS_W-1:0]           act_paths_i,
  input  logic [MAX_PATHS*OFS_W-1:0] ofs_i,
  input  logic                       clear_i,
  output logic [MAX_PATHS*SUM_W-1:0] sum_o,
  output logic [MAX_PATHS*CNT_W-1:0] cnt_o,
  output logic [PKT_W-1:0]           pkt_cnt_o
);
  logic                 qual;
  logic [MAX_PATHS-1:0] lane_en;
  logic [MAX_PATHS-1:0] lane_acc;

  assign qual = en_i & pkt_valid_i & pkt_match_i;

  cfo_lane_select #(.MAX_PATHS(MAX_PATHS), .NSS_W(NSS_W)) u_sel (
    .nss_i     (nss_i),
    .act_i     (act_paths_i),
    .lane_en_o (lane_en)
  );

  for (genvar i = 0; i < MAX_PATHS; i++) begin : g_lane
    assign lane_acc[i] = qual & lane_en[i];
    cfo_path_lane #(.OFS_W(OFS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .acc_i  (lane_acc[i]),
      .ofs_i  (ofs_i[i*OFS_W +: OFS_W]),
      .sum_o  (sum_o[i*SUM_W +: SUM_W]),
      .cnt_o  (cnt_o[i*CNT_W +: CNT_W])
    );
  end

  cfo_pkt_counter #(.PKT_W(PKT_W)) u_pkt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (qual),
    .cnt_o  (pkt_cnt_o)
  );

  a_r3_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qual |-> (lane_acc == '0));
  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qual && pkt_cnt_o != '1) |=> (pkt_cnt_o == $past(pkt_cnt_o) + 1'b1));

endmodule

// File: tb/tb_cfo_accum.sv
module tb_cfo_accum;
  localparam int CLK_P = 10;
  localparam int NP    = 4;
  localparam int OW    = 8;
  localparam int SW    = 12;
  localparam int CW    = 6;
  localparam int PW    = 8;
  localparam int NW    = 3;
  localparam int SMAX  = 2047;
  localparam int SMIN  = -2048;
  localparam int CMAX  = 63;
  localparam int PMAX  = 255;

  logic clk = 0, rst_n = 0;
  logic en, vld, mat, clr;
  logic [NW-1:0] nss, act;
  logic [NP*OW-1:0] ofs;
  logic [NP*SW-1:0] sum;
  logic [NP*CW-1:0] cnt;
  logic [PW-1:0] pkt;

  int checks = 0, errors = 0;
  int e_sum [NP];
  int e_cnt [NP];
  int e_pkt;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cfo_accum #(.MAX_PATHS(NP), .OFS_W(OW), .SUM_W(SW), .CNT_W(CW),
              .PKT_W(PW), .NSS_W(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pkt_valid_i(vld),
    .pkt_match_i(mat), .nss_i(nss), .act_paths_i(act), .ofs_i(ofs),
    .clear_i(clr), .sum_o(sum), .cnt_o(cnt), .pkt_cnt_o(pkt));

  task automatic chk(string tag, string what, int act_v, int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
    end
  endtask

  task automatic compare(string tag);
    for (int i = 0; i < NP; i++) begin
      chk(tag, $sformatf("sum[%0d]", i), int'($signed(sum[i*SW +: SW])), e_sum[i]);
      chk(tag, $sformatf("cnt[%0d]", i), int'(cnt[i*CW +: CW]), e_cnt[i]);
    end
    chk(tag, "pkt", int'(pkt), e_pkt);
  endtask

  task automatic step(bit e, bit v, bit m, bit c, int n, int a,
                      int o0, int o1, int o2, int o3, string tag);
    int o [NP];
    int lim, q;
    o[0] = o0; o[1] = o1; o[2] = o2; o[3] = o3;
    en = e; vld = v; mat = m; clr = c;
    nss = NW'(n); act = NW'(a);
    for (int i = 0; i < NP; i++) ofs[i*OW +: OW] = OW'(o[i]);
    // model
    if (c) for (int i = 0; i < NP; i++) begin e_sum[i] = 0; e_cnt[i] = 0; end
    if (e && v && m) begin
      lim = n; if (a < lim) lim = a; if (NP < lim) lim = NP;
      for (int i = 0; i < lim; i++) begin
        q = e_sum[i] + o[i];
        e_sum[i] = (q > SMAX) ? SMAX : (q < SMIN) ? SMIN : q;
        if (e_cnt[i] < CMAX) e_cnt[i]++;
      end
      e_pkt = (e_pkt == PMAX) ? 0 : e_pkt + 1;
    end
    @(negedge clk);
    vld = 0; clr = 0;
    compare(tag);
  endtask

  initial begin
    en = 0; vld = 0; mat = 0; clr = 0; nss = '0; act = '0; ofs = '0;
    for (int i = 0; i < NP; i++) begin e_sum[i] = 0; e_cnt[i] = 0; end
    e_pkt = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    @(negedge clk);
    compare("R1");

    // R5 basic accumulation, mixed signs and extremes
    step(1,1,1,0,4,4,  5,-3,127,-128, "R5");
    step(1,1,1,0,4,4, -7,10,-1,1,     "R5");
    step(1,1,1,0,4,4,  0,0,0,0,       "R5");
    // R2 unqualified packets
    step(1,1,0,0,4,4, 50,50,50,50, "R2");
    step(1,0,1,0,4,4, 50,50,50,50, "R2");
    step(1,0,0,0,4,4, 50,50,50,50, "R2");
    // R3 disabled
    step(0,1,1,0,4,4, 33,33,33,33, "R3");
    // R4 clamp cases
    step(1,1,1,0,3,2, 9,9,9,9, "R4");
    step(1,1,1,0,1,4, -2,9,9,9, "R4");
    step(1,1,1,0,4,7, 1,2,3,4, "R4");
    step(1,1,1,0,0,4, 1,1,1,1, "R6");
    // R7 clear, counter untouched
    step(1,0,0,1,4,4, 0,0,0,0, "R7");
    // R8 clear with packet
    step(1,1,1,0,4,4, 20,20,20,20, "R8");
    step(1,1,1,1,4,4, -9,8,-7,6, "R8");
    // R4 sweep over every stream / active-path pair
    for (int n = 0; n < 8; n++)
      for (int a = 0; a < 8; a++)
        step(1,1,1,0,n,a, n-a, a, -n, n+a, "R4");
    // R9 positive saturation
    step(1,0,0,1,0,0, 0,0,0,0, "R7");
    for (int k = 0; k < 20; k++) step(1,1,1,0,4,4, 127,127,127,127, "R9");
    step(1,1,1,0,4,4, -128,0,1,127, "R9");
    // R9 negative saturation
    step(1,0,0,1,0,0, 0,0,0,0, "R7");
    for (int k = 0; k < 20; k++) step(1,1,1,0,4,4, -128,-128,-128,-128, "R9");
    step(1,1,1,0,4,4, -1,0,127,-128, "R9");
    // R10 count saturation
    step(1,0,0,1,0,0, 0,0,0,0, "R7");
    for (int k = 0; k < 70; k++) step(1,1,1,0,4,4, 0,0,0,0, "R10");
    // R6 wrap of packet counter
    while (e_pkt != PMAX) step(1,1,1,0,2,3, 1,-1,0,0, "R6");
    step(1,1,1,0,2,3, 1,-1,0,0, "R6");
    step(1,1,1,0,2,3, 1,-1,0,0, "R6");

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule